// File: doc/BRIEF.md
# Truncating Floating-Point Multiplier

This block multiplies two binary floating-point operands in the single-precision interchange layout: a sign bit, an 8-bit biased exponent and a 23-bit fraction with a hidden leading one. The width of the exponent and of the fraction are parameters, so the same RTL also builds a small format. The product sign is the exclusive-or of the operand signs. The exponent is the sum of the operand exponents less the bias, held with two extra bits so that negative and oversized values stay visible. The significands, each with its hidden one, are multiplied in full.

The product is normalized in a single step. If the leading one lands one place above the binary point, the product shifts right by one and the exponent gains one. The stored fraction is then cut off with no rounding. The complete normalized significand product is also driven out, so a following accumulator can use every bit.

Results below the normal range become signed zero and raise an underflow flag. Results at or above the all-ones exponent become signed infinity and raise an overflow flag. An operand with a zero exponent field is treated as zero. An operand with an all-ones exponent field yields a fixed quiet NaN. Operations enter on a valid strobe, one per cycle with no stall, and leave exactly three cycles later.

Top module: `fmul_trunc`

## Requirements
- R1: For every non-NaN result, the result sign (bit W-1) equals the exclusive-or of the two operand sign bits. This includes zero and infinity results.
- R2: Let S be the product of the two significands (1.f). For normal operands with an in-range result, the exponent field is E1 + E2 - bias, plus 1 when S >= 2. The fraction field is the fraction of the normalized S, truncated with no rounding. The bias is 2^(EXP_W-1) - 1.
- R3: `sigProd` is 2*(FRAC_W+1) bits wide. When both exponent fields lie strictly between 0 and all ones, it carries the normalized significand product: the leading one is at bit 2*FRAC_W, and the top bit is 0. It is all zeros when either exponent field is 0 or all ones.
- R4: If the final exponent (after normalization) is 0 or below, the result is signed zero (exponent and fraction fields 0) and `unfFlag` is 1. An intermediate exponent below 0 always ends here.
- R5: If the intermediate exponent is exactly 0 and S >= 2, the result is a normal number with exponent field 1 and no flag.
- R6: If the final exponent is at or above the all-ones value, the result is signed infinity (exponent field all ones, fraction 0) and `ovfFlag` is 1.
- R7: An operand whose exponent field is 0 forces signed zero and `unfFlag` = 1, unless R8 applies.
- R8: An operand whose exponent field is all ones forces the quiet NaN pattern: sign 0, exponent all ones, fraction MSB 1, all other fraction bits 0 (0x7FC00000 at default size). Both flags are 0. This case takes priority over all others.
- R9: `validOut` is `validIn` delayed by exactly three clock cycles. Operations issued on consecutive cycles come out on consecutive cycles, in order.
- R10: `result`, `sigProd` and both flags change only in a cycle where `validOut` is 1, and otherwise hold their last value. All outputs are 0 after reset.
- R11: `ovfFlag` and `unfFlag` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Operands on opA/opB are valid this cycle |
| opA | input | 1+EXP_W+FRAC_W | First operand |
| opB | input | 1+EXP_W+FRAC_W | Second operand |
| validOut | output | 1 | Result outputs carry a new product |
| result | output | 1+EXP_W+FRAC_W | Packed truncated product |
| sigProd | output | 2*(FRAC_W+1) | Normalized full significand product |
| ovfFlag | output | 1 | Result overflowed to infinity |
| unfFlag | output | 1 | Result underflowed to zero |

## Verification
The hardest cases to reach from the ports are the two exponent boundaries. One is an intermediate exponent of exactly zero, where only a product of two or more rescues the result. The other is an exponent sum that lands one step below the all-ones value, where normalization alone tips the result into overflow. Reaching either needs an exact exponent pair and a fraction pair whose significand product crosses two. A reduced instance with a 4-bit exponent and a 3-bit fraction is therefore streamed through every operand pair back to back, which hits both boundaries from every direction. Directed full-width operations then cover the same edges at the default size.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  // Per-stage load strobes from control to datapath
  typedef struct packed {
    logic ldMul;
    logic ldNorm;
    logic ldPack;
  } stageStrb_t;
endpackage

// File: rtl/fmul_ctrl.sv
module fmul_ctrl
  import fmul_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  output stageStrb_t strb,
  output logic       validOut
);
  logic vMul, vNorm, vPack;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vMul  <= 1'b0;
      vNorm <= 1'b0;
      vPack <= 1'b0;
    end else begin
      vMul  <= validIn;
      vNorm <= vMul;
      vPack <= vNorm;
    end
  end

  always_comb begin
    strb.ldMul  = validIn;
    strb.ldNorm = vMul;
    strb.ldPack = vNorm;
  end

  assign validOut = vPack;
endmodule

// File: rtl/fmul_dp.sv
module fmul_dp
  import fmul_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  stageStrb_t                    strb,
  input  logic [EXP_W+FRAC_W:0]         opA,
  input  logic [EXP_W+FRAC_W:0]         opB,
  output logic [EXP_W+FRAC_W:0]         result,
  output logic [2*(FRAC_W+1)-1:0]       sigProd,
  output logic                          ovfFlag,
  output logic                          unfFlag
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int XW     = EXP_W + 2;
  localparam logic signed [XW-1:0] BIAS_X  = XW'((1 << (EXP_W - 1)) - 1);
  localparam logic signed [XW-1:0] EXP_TOP = XW'((1 << EXP_W) - 1);
  localparam logic signed [XW-1:0] EXP_ONE = XW'(1);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // ---------------- stage 1: sign, exponent sum, significand product
  logic [EXP_W-1:0]        expA, expB;
  logic                    inSpecial, inZero;
  logic signed [XW-1:0]    expSum;
  logic [PROD_W-1:0]       rawProd;

  assign expA      = opA[W-2 -: EXP_W];
  assign expB      = opB[W-2 -: EXP_W];
  assign inSpecial = (&expA) | (&expB);
  assign inZero    = (expA == '0) | (expB == '0);
  assign expSum    = $signed({2'b00, expA}) + $signed({2'b00, expB}) - BIAS_X;
  assign rawProd   = PROD_W'({1'b1, opA[FRAC_W-1:0]}) * PROD_W'({1'b1, opB[FRAC_W-1:0]});

  logic                 s1Sign, s1Special, s1Zero;
  logic signed [XW-1:0] s1Exp;
  logic [PROD_W-1:0]    s1Prod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Sign <= 1'b0; s1Special <= 1'b0; s1Zero <= 1'b0;
      s1Exp  <= '0;   s1Prod    <= '0;
    end else if (strb.ldMul) begin
      s1Sign    <= opA[W-1] ^ opB[W-1];
      s1Special <= inSpecial;
      s1Zero    <= inZero;
      s1Exp     <= expSum;
      s1Prod    <= (inSpecial | inZero) ? '0 : rawProd;
    end
  end

  // ---------------- stage 2: one-step normalization
  logic                 carryUp;
  logic signed [XW-1:0] normExp;
  logic [PROD_W-1:0]    normProd;

  assign carryUp  = s1Prod[PROD_W-1];
  assign normProd = carryUp ? (s1Prod >> 1) : s1Prod;
  assign normExp  = s1Exp + $signed({{(XW-1){1'b0}}, carryUp});

  logic                 s2Sign, s2Special, s2Zero;
  logic signed [XW-1:0] s2Exp;
  logic [PROD_W-1:0]    s2Prod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s2Sign <= 1'b0; s2Special <= 1'b0; s2Zero <= 1'b0;
      s2Exp  <= '0;   s2Prod    <= '0;
    end else if (strb.ldNorm) begin
      s2Sign    <= s1Sign;
      s2Special <= s1Special;
      s2Zero    <= s1Zero;
      s2Exp     <= normExp;
      s2Prod    <= normProd;
    end
  end

  // ---------------- stage 3: range check, truncate and pack
  logic [W-1:0] packNext;
  logic         ovfNext, unfNext;

  always_comb begin
    ovfNext = 1'b0;
    unfNext = 1'b0;
    if (s2Special) begin
      packNext = QNAN;
    end else if (s2Zero || (s2Exp < EXP_ONE)) begin
      packNext = {s2Sign, {(W-1){1'b0}}};
      unfNext  = 1'b1;
    end else if (s2Exp >= EXP_TOP) begin
      packNext = {s2Sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      ovfNext  = 1'b1;
    end else begin
      packNext = {s2Sign, s2Exp[EXP_W-1:0], s2Prod[PROD_W-3 -: FRAC_W]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result  <= '0;
      sigProd <= '0;
      ovfFlag <= 1'b0;
      unfFlag <= 1'b0;
    end else if (strb.ldPack) begin
      result  <= packNext;
      sigProd <= s2Prod;
      ovfFlag <= ovfNext;
      unfFlag <= unfNext;
    end
  end
endmodule

// File: rtl/fmul_trunc.sv
module fmul_trunc #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          validIn,
  input  logic [EXP_W+FRAC_W:0]         opA,
  input  logic [EXP_W+FRAC_W:0]         opB,
  output logic                          validOut,
  output logic [EXP_W+FRAC_W:0]         result,
  output logic [2*(FRAC_W+1)-1:0]       sigProd,
  output logic                          ovfFlag,
  output logic                          unfFlag
);
  fmul_pkg::stageStrb_t strb;

  fmul_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .strb     (strb),
    .validOut (validOut)
  );

  fmul_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .opA     (opA),
    .opB     (opB),
    .result  (result),
    .sigProd (sigProd),
    .ovfFlag (ovfFlag),
    .unfFlag (unfFlag)
  );
endmodule

// File: rtl/fmul_trunc_chk.sv
module fmul_trunc_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    validIn,
  input logic [EXP_W+FRAC_W:0]   opA,
  input logic [EXP_W+FRAC_W:0]   opB,
  input logic                    validOut,
  input logic [EXP_W+FRAC_W:0]   result,
  input logic [2*(FRAC_W+1)-1:0] sigProd,
  input logic                    ovfFlag,
  input logic                    unfFlag
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int PROD_W = 2 * (FRAC_W + 1);

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  logic nanOut;
  assign nanOut = (&result[W-2 -: EXP_W]) && (|result[FRAC_W-1:0]);

  // R11
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfFlag && unfFlag));

  // R6
  ovf_is_inf_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag |-> ((&result[W-2 -: EXP_W]) && (result[FRAC_W-1:0] == '0)));

  // R4
  unf_is_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    unfFlag |-> (result[W-2:0] == '0));

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (validOut == $past(validIn, 3)));

  // R1
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && (sinceRst == 2'd3) && !nanOut) |->
      (result[W-1] == $past(opA[W-1] ^ opB[W-1], 3)));

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validOut |-> ($stable(result) && $stable(sigProd) && $stable(ovfFlag) && $stable(unfFlag)));

  // R3
  sig_normalized_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && (sigProd != '0)) |-> (!sigProd[PROD_W-1] && sigProd[PROD_W-2]));

  // R8
  nan_no_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    nanOut |-> (!ovfFlag && !unfFlag && !result[W-1]));
endmodule

bind fmul_trunc fmul_trunc_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rstN(rstN), .validIn(validIn), .opA(opA), .opB(opB),
  .validOut(validOut), .result(result), .sigProd(sigProd),
  .ovfFlag(ovfFlag), .unfFlag(unfFlag)
);

// File: tb/test_fmul_trunc.sv
module test_fmul_trunc;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // full-width instance
  logic        validIn = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        validOut, ovfFlag, unfFlag;
  logic [31:0] result;
  logic [47:0] sigProd;

  fmul_trunc i_fmul_trunc (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opA(opA), .opB(opB),
    .validOut(validOut), .result(result), .sigProd(sigProd),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  // reduced instance: 4-bit exponent, 3-bit fraction
  logic       mValidIn = 1'b0;
  logic [7:0] mA = '0, mB = '0;
  logic       mValidOut, mOvf, mUnf;
  logic [7:0] mResult, mSig;

  fmul_trunc #(.EXP_W(4), .FRAC_W(3)) i_fmul_trunc_mini (
    .clk(clk), .rstN(rstN), .validIn(mValidIn), .opA(mA), .opB(mB),
    .validOut(mValidOut), .result(mResult), .sigProd(mSig),
    .ovfFlag(mOvf), .unfFlag(mUnf)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Arithmetic reference model for any exponent/fraction width
  task automatic model(input int ew, input int fw, input longint a, input longint b,
                       output longint r, output longint s, output bit o, output bit u,
                       output string tag);
    longint bias = (longint'(1) << (ew - 1)) - 1;
    longint emax = (longint'(1) << ew) - 1;
    longint fmsk = (longint'(1) << fw) - 1;
    longint sgn  = ((a >> (ew + fw)) ^ (b >> (ew + fw))) & 1;
    longint ea = (a >> fw) & emax, eb = (b >> fw) & emax;
    longint p, e;
    bit nrm;
    o = 0; u = 0; s = 0;
    if (ea == emax || eb == emax) begin
      r = (emax << fw) | (longint'(1) << (fw - 1)); tag = "R8";
    end else if (ea == 0 || eb == 0) begin
      r = sgn << (ew + fw); u = 1; tag = "R7";
    end else begin
      p = ((longint'(1) << fw) + (a & fmsk)) * ((longint'(1) << fw) + (b & fmsk));
      nrm = ((p >> (2 * fw + 1)) & 1) != 0;
      if (nrm) p = p >> 1;
      s = p;
      e = ea + eb - bias + (nrm ? 1 : 0);
      if (e <= 0) begin
        r = sgn << (ew + fw); u = 1; tag = "R4";
      end else if (e >= emax) begin
        r = (sgn << (ew + fw)) | (emax << fw); o = 1; tag = "R6";
      end else begin
        r = (sgn << (ew + fw)) | (e << fw) | ((p >> fw) & fmsk);
        tag = (ea + eb - bias == 0) ? "R5" : "R2";
      end
    end
  endtask

  // One full-width operation, latency and outputs checked (R9 and per-tag)
  task automatic runBig(input logic [31:0] a, input logic [31:0] b, input string why);
    longint er, es; bit eo, eu; string tg;
    model(8, 23, a, b, er, es, eo, eu, tg);
    @(negedge clk); validIn = 1'b1; opA = a; opB = b;
    @(negedge clk); validIn = 1'b0;
    chk("R9 not valid after 1 cycle", validOut, 0);
    @(negedge clk);
    chk("R9 not valid after 2 cycles", validOut, 0);
    @(negedge clk);
    chk("R9 valid after 3 cycles", validOut, 1);
    chk({tg, " result ", why}, result, er);
    chk({"R3 sigProd ", why}, sigProd, es);
    chk({"R6 ovfFlag ", why}, ovfFlag, eo);
    chk({"R4 unfFlag ", why}, unfFlag, eu);
  endtask

  // Streaming monitor for the reduced instance
  bit monOn = 1'b0;
  int outIdx = 0;
  always @(negedge clk) begin
    if (monOn && mValidOut) begin
      longint er, es; bit eo, eu; string tg;
      model(4, 3, outIdx >> 8, outIdx & 255, er, es, eo, eu, tg);
      chk({tg, " mini result"}, mResult, er);
      chk("R3 mini sigProd", mSig, es);
      chk("R6/R4 mini flags", {mOvf, mUnf}, {eo, eu});
      if (mOvf && mUnf) chk("R11 mini flags exclusive", 1, 0);
      outIdx++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 reset result", result, 0);
    chk("R10 reset sigProd", sigProd, 0);
    chk("R10 reset flags", {ovfFlag, unfFlag}, 0);
    chk("R9 reset validOut", validOut, 0);
    chk("R10 reset mini result", mResult, 0);

    runBig(32'h42200000, 32'hC0F00000, "40 x -7.5");
    chk("R2 literal -300", result, 32'hC3960000);
    runBig(32'h3F800000, 32'h3F800000, "1 x 1");
    runBig(32'h3FFFFFFF, 32'h3FFFFFFF, "max fractions");
    runBig(32'hBF800000, 32'hBF800000, "R1 neg x neg");
    chk("R1 neg x neg positive", result[31], 0);
    runBig(32'hBF800000, 32'h3F800000, "R1 neg x pos");
    chk("R1 neg x pos negative", result[31], 1);
    runBig(32'h20400000, 32'h1FC00000, "zero exp rescued");
    chk("R5 rescued literal", result, 32'h00900000);
    runBig(32'h20000000, 32'h1F800000, "zero exp not rescued");
    chk("R4 zero exp underflow", {unfFlag, result}, {1'b1, 32'h0});
    runBig(32'h80800000, 32'h00800000, "deep underflow");
    chk("R4 signed zero", result, 32'h80000000);
    runBig(32'h7F000000, 32'h7F000000, "overflow");
    runBig(32'hFF000000, 32'h7F000000, "neg overflow");
    chk("R6 neg infinity", result, 32'hFF800000);
    runBig(32'h5F000000, 32'h5F800000, "exp 254 edge");
    chk("R6 edge no overflow", {ovfFlag, result}, {1'b0, 32'h7F000000});
    runBig(32'h5F400000, 32'h5FC00000, "normalize into overflow");
    chk("R6 normalize overflow", ovfFlag, 1);
    runBig(32'h00000001, 32'h3F800000, "denormal");
    runBig(32'h80000000, 32'h40000000, "neg zero operand");
    chk("R7 neg zero", {unfFlag, result}, {1'b1, 32'h80000000});
    runBig(32'h7F800000, 32'h00000000, "inf x zero");
    chk("R8 qnan literal", result, 32'h7FC00000);
    runBig(32'hFFC00001, 32'h3F800000, "nan operand");

    // R10: new operands without validIn leave outputs untouched
    @(negedge clk); opA = 32'h3F800000; opB = 32'h40000000;
    repeat (5) @(negedge clk);
    chk("R10 hold result", result, 32'h7FC00000);
    chk("R10 hold flags", {ovfFlag, unfFlag}, 0);

    // exhaustive back-to-back stream on reduced instance (R9 throughput)
    monOn = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      @(negedge clk); mValidIn = 1'b1; mA = i[15:8]; mB = i[7:0];
    end
    @(negedge clk); mValidIn = 1'b0; mA = 8'h38; mB = 8'h38;
    repeat (6) @(negedge clk);
    chk("R9 all streamed results seen", outIdx, 65536);
    begin
      longint er, es; bit eo, eu; string tg;
      model(4, 3, 255, 255, er, es, eo, eu, tg);
      chk("R10 mini hold after stream", mResult, er);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule